// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the hardware side of taking an exception or interrupt on a 32-bit core. A request arrives with a two-bit cause and three candidate vectors: trap, fault and interrupt. On the cycle it is accepted, the block captures the core's current context: program counter, delay-slot count, stack pointer, kernel stack pointer, status word and exception base address. From that snapshot it works out every architectural register update. It then presents all of them together as one write strobe.

After that update cycle the block reads the handler address from memory. It uses a request channel (valid/ready, 32-bit address) and a response channel (valid, 32-bit data). The word returned is written to the program counter, and a one-cycle done pulse closes the entry. Decoding, interrupt arbitration and address translation belong to neighbouring blocks. The core applies the write strobes to its register file.

Top module: `exc_entry_seq`

## Requirements
- R1: The cause code selects the vector. 0 is an external interrupt and uses `irq_vec`. 1 is a break and uses `trap_vec`. 2 is a non-maskable interrupt and always uses vector 0. 3 is a bus fault and uses `fault_vec`.
- R2: In the update cycle, cause 2 writes the captured PC unmodified to the NMI return register (`nrp_we`). Every other cause writes the exception return register (`erp_we`). The two strobes are never both high.
- R3: The exception-status value holds the low 8 bits of the chosen vector in bits 15:8. All its other bits are zero.
- R4: The exception return value is the captured PC minus the captured delay-slot count. `dslot_clr` is high in the update cycle exactly when that count is nonzero.
- R5: When the captured status bit 8 (user mode) is set, the update saves the captured SP to the user-SP register (`usp_we`) and loads the kernel SP into SP (`sp_we`). When the bit is clear, neither strobe rises.
- R6: The new status word is built from the captured word, with bit 9 (the NMI mask) first cleared when the cause is 2. Bits 31:30 are kept, old bits 19:0 move to 29:10, and bits 9:0 become zero, so user mode ends cleared.
- R7: The handler is fetched from `exc_base + vector*4` (modulo 2^32). The response data is written to the PC (`pc_we`, `pc_val`) in the cycle the response is accepted.
- R8: The update strobe is high for the single cycle after acceptance. The fetch request starts the next cycle and holds a stable address until `mem_req_ready`. A response is accepted only after the request handshake. `done` pulses for one cycle after the PC write.
- R9: `busy` is high from the cycle after acceptance through the `done` cycle. Requests that arrive while busy start no second entry.
- R10: A bus-fault request that arrives while a bus-fault entry is still pending raises `dbl_fault` for one cycle, in the cycle that follows. A bus-fault request during any other entry does not raise it.
- R11: With synchronous active-low reset, the block is idle, with `busy`, `done`, `dbl_fault`, every write strobe and `mem_req_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Exception request, sampled when idle |
| req_cause | input | 2 | Cause code (see R1) |
| trap_vec | input | 8 | Vector for break |
| fault_vec | input | 8 | Vector for bus fault |
| irq_vec | input | 8 | Vector from interrupt controller |
| cur_pc | input | 32 | Current program counter |
| cur_dslot | input | 2 | Delay-slot count |
| cur_sp | input | 32 | Current stack pointer |
| kern_sp | input | 32 | Kernel stack pointer |
| cur_stat | input | 32 | Current status word |
| exc_base | input | 32 | Exception vector table base |
| busy | output | 1 | Entry in progress |
| done | output | 1 | One-cycle completion pulse |
| dbl_fault | output | 1 | Recursive bus-fault error pulse |
| upd_we | output | 1 | Register update commit strobe |
| erp_we | output | 1 | Exception return register write |
| erp_val | output | 32 | Exception return value |
| nrp_we | output | 1 | NMI return register write |
| nrp_val | output | 32 | NMI return value |
| exs_val | output | 32 | Exception-status value |
| stat_val | output | 32 | New status word |
| usp_we | output | 1 | User-SP register write |
| usp_val | output | 32 | User-SP value |
| sp_we | output | 1 | Stack pointer write |
| sp_val | output | 32 | New stack pointer |
| dslot_clr | output | 1 | Clear delay-slot count |
| pc_we | output | 1 | PC write |
| pc_val | output | 32 | New PC (handler address) |
| mem_req_valid | output | 1 | Handler fetch request valid |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_addr | output | 32 | Handler fetch address |
| mem_rsp_valid | input | 1 | Fetch response valid |
| mem_rsp_data | input | 32 | Fetch response data |

## Verification
The request is presented one cycle before any result appears. The register-update strobe and all its values are due one cycle after acceptance. The fetch request is due one cycle after that, and it stays up for as many cycles as ready is withheld. The PC write is combinational on the accepted response, `done` follows one cycle later, and `busy` falls one cycle after `done`. Each scenario task drives inputs just after the falling edge and samples shortly after it, stepping exactly these cycle counts. It changes the context inputs after acceptance, so any late sampling in the design would show up as a mismatch. A recursive-fault pulse is checked in the cycle after the injected request and again one cycle later, to confirm it has cleared.

// File: rtl/exc_pkg.sv
// Package: shared cause codes, sequencer states and status-word bit positions
// for the exception entry sequencer. Assumes a two-bit cause encoding.
package exc_pkg;

    typedef enum logic [1:0] {
        CAUSE_IRQ = 2'd0,
        CAUSE_BRK = 2'd1,
        CAUSE_NMI = 2'd2,
        CAUSE_BUS = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_UPDATE = 2'd1,
        ST_FETCH  = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_e;

    // Status-word bit positions that the sequencer inspects or modifies.
    localparam int unsigned STAT_U_BIT = 8;
    localparam int unsigned STAT_M_BIT = 9;

endpackage

// File: rtl/exc_vec_sel.sv
// Module: exc_vec_sel
// Picks the exception vector from the cause code. The NMI vector is fixed at
// zero. Purely combinational; assumes the vectors are stable with the request.
module exc_vec_sel
    import exc_pkg::*;
#(
    parameter int unsigned VEC_W = 8
) (
    input  logic [1:0]       cause,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic [VEC_W-1:0] fault_vec,
    input  logic [VEC_W-1:0] irq_vec,
    output logic [VEC_W-1:0] vec,
    output logic             is_nmi
);

    // Vector multiplexer keyed on the cause code.
    always_comb begin
        is_nmi = 1'b0;
        unique case (cause_e'(cause))
            CAUSE_BRK: vec = trap_vec;
            CAUSE_NMI: begin
                vec    = '0;
                is_nmi = 1'b1;
            end
            CAUSE_BUS: vec = fault_vec;
            default:   vec = irq_vec;
        endcase
    end

endmodule

// File: rtl/exc_ctx_update.sv
// Module: exc_ctx_update
// Computes every architectural register write of an exception entry from a
// captured context snapshot: return address (with delay-slot rewind),
// exception-status index, stack swap and the status-word mode-stack shift.
// Combinational; write strobes are qualified by the commit input.
module exc_ctx_update
    import exc_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned VEC_W = 8,
    parameter int unsigned DS_W  = 2,
    parameter int unsigned KEEP  = 2,
    parameter int unsigned SHIFT = 10
) (
    input  logic             commit,
    input  logic             is_nmi,
    input  logic [VEC_W-1:0] vec,
    input  logic [XLEN-1:0]  pc,
    input  logic [DS_W-1:0]  dslot,
    input  logic [XLEN-1:0]  sp,
    input  logic [XLEN-1:0]  ksp,
    input  logic [XLEN-1:0]  stat,
    output logic             erp_we,
    output logic [XLEN-1:0]  erp_val,
    output logic             nrp_we,
    output logic [XLEN-1:0]  nrp_val,
    output logic [XLEN-1:0]  exs_val,
    output logic [XLEN-1:0]  stat_val,
    output logic             usp_we,
    output logic [XLEN-1:0]  usp_val,
    output logic             sp_we,
    output logic [XLEN-1:0]  sp_val,
    output logic             dslot_clr
);

    localparam int unsigned LOW_W = XLEN - KEEP - SHIFT;
    localparam int unsigned IDX_W = 8;
    localparam int unsigned IDX_LO = 8;

    logic [XLEN-1:0] stat_pre;
    logic [IDX_W-1:0] idx;
    logic            user_mode;

    // Return-address selection and delay-slot rewind.
    always_comb begin
        erp_we    = commit & ~is_nmi;
        nrp_we    = commit & is_nmi;
        erp_val   = pc - XLEN'(dslot);
        nrp_val   = pc;
        dslot_clr = commit & (dslot != '0);
    end

    // Exception-status register: vector index field only.
    always_comb begin
        idx     = IDX_W'(vec);
        exs_val = '0;
        exs_val[IDX_LO +: IDX_W] = idx;
    end

    // Stack-pointer swap when leaving user mode.
    always_comb begin
        user_mode = stat[STAT_U_BIT];
        usp_we    = commit & user_mode;
        usp_val   = sp;
        sp_we     = commit & user_mode;
        sp_val    = ksp;
    end

    // Status word: optional NMI mask clear, then the mode-stack shift.
    always_comb begin
        stat_pre = stat;
        if (is_nmi) begin
            stat_pre[STAT_M_BIT] = 1'b0;
        end
        stat_val = {stat_pre[XLEN-1 -: KEEP], stat_pre[LOW_W-1:0], {SHIFT{1'b0}}};
    end

endmodule

// File: rtl/exc_seq_fsm.sv
// Module: exc_seq_fsm
// Control for the entry sequence: IDLE -> UPDATE -> FETCH -> DONE. Tracks the
// pending cause, runs the fetch handshake (request first, then response) and
// flags a bus fault that arrives while a bus fault is pending.
// Assumes the memory returns exactly one response per accepted request.
module exc_seq_fsm
    import exc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_cause,
    input  logic       mem_req_ready,
    input  logic       mem_rsp_valid,
    output logic       cap_en,
    output logic       upd_strobe,
    output logic       mem_req_valid,
    output logic       pc_we,
    output logic       done,
    output logic       busy,
    output logic       dbl_fault
);

    seq_state_e state_q;
    cause_e     pend_cause_q;
    logic       pend_valid_q;
    logic       req_pend_q;
    logic       dbl_fault_q;
    logic       recursive;

    // Decoded state outputs.
    always_comb begin
        busy          = (state_q != ST_IDLE);
        cap_en        = (state_q == ST_IDLE) && req_valid;
        upd_strobe    = (state_q == ST_UPDATE);
        mem_req_valid = (state_q == ST_FETCH) && req_pend_q;
        pc_we         = (state_q == ST_FETCH) && !req_pend_q && mem_rsp_valid;
        done          = (state_q == ST_DONE);
        dbl_fault     = dbl_fault_q;
        recursive     = pend_valid_q && (pend_cause_q == CAUSE_BUS) &&
                        req_valid && (cause_e'(req_cause) == CAUSE_BUS);
    end

    // State register, pending cause and fetch handshake tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            pend_cause_q <= CAUSE_IRQ;
            pend_valid_q <= 1'b0;
            req_pend_q   <= 1'b0;
            dbl_fault_q  <= 1'b0;
        end else begin
            dbl_fault_q <= recursive;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        state_q      <= ST_UPDATE;
                        pend_valid_q <= 1'b1;
                        pend_cause_q <= cause_e'(req_cause);
                    end
                end
                ST_UPDATE: begin
                    state_q    <= ST_FETCH;
                    req_pend_q <= 1'b1;
                end
                ST_FETCH: begin
                    if (req_pend_q) begin
                        if (mem_req_ready) begin
                            req_pend_q <= 1'b0;
                        end
                    end else if (mem_rsp_valid) begin
                        state_q <= ST_DONE;
                    end
                end
                default: begin
                    state_q      <= ST_IDLE;
                    pend_valid_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
// Module: exc_entry_seq (top)
// Exception entry sequencer. Captures the core context on request acceptance,
// commits all register updates in one cycle, fetches the handler address from
// base + vector*4 and writes it to the PC. Requests while busy start nothing.
// Assumes the core applies the write strobes in the cycle they are high.
module exc_entry_seq
    import exc_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned DS_W       = 2,
    parameter int unsigned STAT_KEEP  = 2,
    parameter int unsigned STAT_SHIFT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_cause,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic [VEC_W-1:0] fault_vec,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [DS_W-1:0]  cur_dslot,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic [XLEN-1:0]  kern_sp,
    input  logic [XLEN-1:0]  cur_stat,
    input  logic [XLEN-1:0]  exc_base,
    output logic             busy,
    output logic             done,
    output logic             dbl_fault,
    output logic             upd_we,
    output logic             erp_we,
    output logic [XLEN-1:0]  erp_val,
    output logic             nrp_we,
    output logic [XLEN-1:0]  nrp_val,
    output logic [XLEN-1:0]  exs_val,
    output logic [XLEN-1:0]  stat_val,
    output logic             usp_we,
    output logic [XLEN-1:0]  usp_val,
    output logic             sp_we,
    output logic [XLEN-1:0]  sp_val,
    output logic             dslot_clr,
    output logic             pc_we,
    output logic [XLEN-1:0]  pc_val,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [XLEN-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [XLEN-1:0]  mem_rsp_data
);

    localparam int unsigned WORD_SHIFT = 2;

    logic             cap_en;
    logic [VEC_W-1:0] vec_sel;
    logic             nmi_sel;

    logic [VEC_W-1:0] vec_q;
    logic             nmi_q;
    logic [XLEN-1:0]  pc_q;
    logic [DS_W-1:0]  dslot_q;
    logic [XLEN-1:0]  sp_q;
    logic [XLEN-1:0]  ksp_q;
    logic [XLEN-1:0]  stat_q;
    logic [XLEN-1:0]  base_q;

    exc_vec_sel #(
        .VEC_W (VEC_W)
    ) vec_sel_i (
        .cause     (req_cause),
        .trap_vec  (trap_vec),
        .fault_vec (fault_vec),
        .irq_vec   (irq_vec),
        .vec       (vec_sel),
        .is_nmi    (nmi_sel)
    );

    exc_seq_fsm fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_cause     (req_cause),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .cap_en        (cap_en),
        .upd_strobe    (upd_we),
        .mem_req_valid (mem_req_valid),
        .pc_we         (pc_we),
        .done          (done),
        .busy          (busy),
        .dbl_fault     (dbl_fault)
    );

    // Context snapshot taken in the acceptance cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= '0;
            nmi_q   <= 1'b0;
            pc_q    <= '0;
            dslot_q <= '0;
            sp_q    <= '0;
            ksp_q   <= '0;
            stat_q  <= '0;
            base_q  <= '0;
        end else if (cap_en) begin
            vec_q   <= vec_sel;
            nmi_q   <= nmi_sel;
            pc_q    <= cur_pc;
            dslot_q <= cur_dslot;
            sp_q    <= cur_sp;
            ksp_q   <= kern_sp;
            stat_q  <= cur_stat;
            base_q  <= exc_base;
        end
    end

    exc_ctx_update #(
        .XLEN  (XLEN),
        .VEC_W (VEC_W),
        .DS_W  (DS_W),
        .KEEP  (STAT_KEEP),
        .SHIFT (STAT_SHIFT)
    ) ctx_i (
        .commit    (upd_we),
        .is_nmi    (nmi_q),
        .vec       (vec_q),
        .pc        (pc_q),
        .dslot     (dslot_q),
        .sp        (sp_q),
        .ksp       (ksp_q),
        .stat      (stat_q),
        .erp_we    (erp_we),
        .erp_val   (erp_val),
        .nrp_we    (nrp_we),
        .nrp_val   (nrp_val),
        .exs_val   (exs_val),
        .stat_val  (stat_val),
        .usp_we    (usp_we),
        .usp_val   (usp_val),
        .sp_we     (sp_we),
        .sp_val    (sp_val),
        .dslot_clr (dslot_clr)
    );

    // Handler fetch address and new PC.
    always_comb begin
        mem_req_addr = base_q + (XLEN'(vec_q) << WORD_SHIFT);
        pc_val       = mem_rsp_data;
    end

endmodule

// File: rtl/exc_entry_seq_chk.sv
// Module: exc_entry_seq_chk
// Temporal checks on the sequencer's ports, attached to every instance of the
// top by the bind below. Assumes synchronous active-low reset.
module exc_entry_seq_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            done,
    input logic            dbl_fault,
    input logic            upd_we,
    input logic            erp_we,
    input logic            nrp_we,
    input logic            pc_we,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr
);

    assert_one_return_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({erp_we, nrp_we}));

    assert_return_in_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (erp_we || nrp_we) |-> upd_we);

    assert_pc_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> done);

    assert_update_then_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_we |=> (mem_req_valid && !upd_we));

    assert_fetch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (busy && upd_we));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!upd_we && !mem_req_valid && !pc_we && !done));

    assert_dbl_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_fault |-> $past(busy));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .busy          (busy),
    .done          (done),
    .dbl_fault     (dbl_fault),
    .upd_we        (upd_we),
    .erp_we        (erp_we),
    .nrp_we        (nrp_we),
    .pc_we         (pc_we),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/exc_entry_seq_tb_top.sv
// Directed bench for exc_entry_seq: one task per scenario, each checking its
// own results at the falling edge plus 1 ns.
module exc_entry_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cause = 2'd0;
    logic [7:0]  trap_vec = 8'd0, fault_vec = 8'd0, irq_vec = 8'd0;
    logic [31:0] cur_pc = '0, cur_sp = '0, kern_sp = '0, cur_stat = '0, exc_base = '0;
    logic [1:0]  cur_dslot = '0;
    logic        busy, done, dbl_fault, upd_we, erp_we, nrp_we, usp_we, sp_we;
    logic        dslot_clr, pc_we, mem_req_valid;
    logic [31:0] erp_val, nrp_val, exs_val, stat_val, usp_val, sp_val, pc_val, mem_req_addr;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    exc_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cause(req_cause),
        .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec),
        .cur_pc(cur_pc), .cur_dslot(cur_dslot), .cur_sp(cur_sp), .kern_sp(kern_sp),
        .cur_stat(cur_stat), .exc_base(exc_base), .busy(busy), .done(done),
        .dbl_fault(dbl_fault), .upd_we(upd_we), .erp_we(erp_we), .erp_val(erp_val),
        .nrp_we(nrp_we), .nrp_val(nrp_val), .exs_val(exs_val), .stat_val(stat_val),
        .usp_we(usp_we), .usp_val(usp_val), .sp_we(sp_we), .sp_val(sp_val),
        .dslot_clr(dslot_clr), .pc_we(pc_we), .pc_val(pc_val),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    // One full entry; inj injects a second request while busy.
    task automatic run_entry(input string name, input logic [1:0] cause,
                             input logic [7:0] tv, input logic [7:0] fv, input logic [7:0] iv,
                             input logic [31:0] pc, input logic [1:0] ds,
                             input logic [31:0] sp, input logic [31:0] ksp,
                             input logic [31:0] st, input logic [31:0] base,
                             input int stall, input bit inj, input logic [1:0] inj_cause,
                             input logic [31:0] handler);
        logic        nmi;
        logic [7:0]  vec;
        logic [31:0] s, exp_stat, exp_addr;
        logic        exp_dbl;
        nmi = (cause == 2'd2);
        case (cause)
            2'd0: vec = iv;
            2'd1: vec = tv;
            2'd2: vec = 8'd0;
            default: vec = fv;
        endcase
        s = st;
        if (nmi) s[9] = 1'b0;
        exp_stat = {s[31:30], s[19:0], 10'b0};
        exp_addr = base + {22'd0, vec, 2'b00};
        exp_dbl  = inj && (cause == 2'd3) && (inj_cause == 2'd3);

        @(negedge clk);
        req_valid = 1'b1; req_cause = cause; trap_vec = tv; fault_vec = fv; irq_vec = iv;
        cur_pc = pc; cur_dslot = ds; cur_sp = sp; kern_sp = ksp; cur_stat = st; exc_base = base;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;

        @(negedge clk);
        req_valid = inj; req_cause = inj_cause;
        cur_pc = ~pc; cur_dslot = ~ds; cur_sp = ~sp; kern_sp = ~ksp; cur_stat = ~st;
        exc_base = ~base; trap_vec = ~tv; fault_vec = ~fv; irq_vec = ~iv;
        #1;
        chk({name, " R9 busy after accept"}, 32'(busy), 32'd1);
        chk({name, " R8 update strobe"}, 32'(upd_we), 32'd1);
        chk({name, " R2 erp_we"}, 32'(erp_we), 32'(!nmi));
        chk({name, " R2 nrp_we"}, 32'(nrp_we), 32'(nmi));
        if (nmi) chk({name, " R2 nrp value"}, nrp_val, pc);
        else     chk({name, " R4 erp rewind"}, erp_val, pc - {30'd0, ds});
        chk({name, " R4 dslot_clr"}, 32'(dslot_clr), 32'(ds != 2'd0));
        chk({name, " R1 R3 exs"}, exs_val, {16'd0, vec, 8'd0});
        chk({name, " R6 status"}, stat_val, exp_stat);
        chk({name, " R5 usp_we"}, 32'(usp_we), 32'(st[8]));
        chk({name, " R5 sp_we"}, 32'(sp_we), 32'(st[8]));
        if (st[8]) begin
            chk({name, " R5 usp value"}, usp_val, sp);
            chk({name, " R5 sp value"}, sp_val, ksp);
        end

        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk({name, " R8 single update"}, 32'(upd_we), 32'd0);
        chk({name, " R8 fetch valid"}, 32'(mem_req_valid), 32'd1);
        chk({name, " R1 R7 fetch addr"}, mem_req_addr, exp_addr);
        chk({name, " R10 dbl_fault"}, 32'(dbl_fault), 32'(exp_dbl));
        for (int i = 0; i < stall; i++) begin
            @(negedge clk); #1;
            chk({name, " R8 fetch held"}, 32'(mem_req_valid), 32'd1);
            chk({name, " R8 addr stable"}, mem_req_addr, exp_addr);
        end
        mem_req_ready = 1'b1;

        @(negedge clk);
        mem_req_ready = 1'b0;
        #1;
        chk({name, " R8 fetch dropped"}, 32'(mem_req_valid), 32'd0);
        chk({name, " R8 no pc before rsp"}, 32'(pc_we), 32'd0);
        chk({name, " R10 dbl_fault cleared"}, 32'(dbl_fault), 32'd0);
        mem_rsp_valid = 1'b1; mem_rsp_data = handler;
        #1;
        chk({name, " R7 pc_we"}, 32'(pc_we), 32'd1);
        chk({name, " R7 pc value"}, pc_val, handler);

        @(negedge clk);
        mem_rsp_valid = 1'b0;
        #1;
        chk({name, " R8 done"}, 32'(done), 32'd1);
        chk({name, " R9 busy in done"}, 32'(busy), 32'd1);

        @(negedge clk); #1;
        chk({name, " R8 done one cycle"}, 32'(done), 32'd0);
        chk({name, " R9 idle after"}, 32'(busy), 32'd0);
        chk({name, " R9 no second entry"}, 32'(upd_we), 32'd0);
        @(negedge clk); #1;
        chk({name, " R9 still idle"}, 32'(busy | upd_we), 32'd0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R11 busy", 32'(busy), 32'd0);
        chk("R11 done", 32'(done), 32'd0);
        chk("R11 dbl_fault", 32'(dbl_fault), 32'd0);
        chk("R11 strobes", 32'({upd_we, erp_we, nrp_we, usp_we, sp_we, pc_we}), 32'd0);
        chk("R11 mem_req_valid", 32'(mem_req_valid), 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        test_reset();
        // Interrupt from user mode, no delay slot.
        run_entry("irq_user", 2'd0, 8'h11, 8'h22, 8'h21, 32'h0000_4000, 2'd0,
                  32'h0000_7FF0, 32'h0000_9000, 32'h0000_0100, 32'h8000_0000,
                  0, 1'b0, 2'd0, 32'h1234_5678);
        // Break in a delay slot, kernel mode, bus fault raised while pending break.
        run_entry("brk_dslot", 2'd1, 8'h3C, 8'h22, 8'h21, 32'h0001_0010, 2'd2,
                  32'h0000_1000, 32'h0000_2000, 32'hC000_0200, 32'h0000_8000,
                  1, 1'b1, 2'd3, 32'hCAFE_0000);
        // NMI from user mode with mask set: vector 0, NRP, mask cleared.
        run_entry("nmi_user", 2'd2, 8'h77, 8'h66, 8'h55, 32'h0002_0004, 2'd1,
                  32'hAAAA_0000, 32'hBBBB_0000, 32'h4000_0301, 32'h0000_C000,
                  0, 1'b0, 2'd0, 32'h0000_0ABC);
        // Bus fault, all status bits set, address wraps, recursive bus fault.
        run_entry("bus_recur", 2'd3, 8'h01, 8'hFF, 8'h02, 32'hFFFF_FFF0, 2'd3,
                  32'h1111_1111, 32'h2222_2222, 32'hFFFF_FFFF, 32'hFFFF_FF00,
                  3, 1'b1, 2'd3, 32'hDEAD_BEEF);
        // Interrupt with another interrupt arriving while busy: ignored.
        run_entry("irq_ignore", 2'd0, 8'h00, 8'h00, 8'h80, 32'h0000_0100, 2'd0,
                  32'h0000_0000, 32'h0000_0040, 32'h0000_0000, 32'h0000_0000,
                  2, 1'b1, 2'd0, 32'h0000_0200);
        summary();
        $finish;
    end

endmodule